// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block owns the stack pointer of a small processor core together with an 8-bit extension register. In the narrow mode the stack lives in a 256-byte internal RAM and only the stack pointer forms the address. In the wide mode, selected by a static enable input, the two low bits of the extension register sit above the stack pointer. This gives a 10-bit stack inside a 4 KB internal RAM, and the unit raises a select line that steers the access to that larger RAM.

The core hands the unit single-byte push and pop requests, or asks it to run a whole call or return frame. A call frame stores the return address one byte per clock, low byte first. A return frame reads it back in the opposite order and reports the restored program counter. With the 24-bit address mode set, frames carry a third byte and a return takes one extra clock. An interrupt entry in that mode still stores three bytes, but the vector it hands back has a zero top byte. The RAM is assumed to have an asynchronous read port: read data is valid in the same cycle as the read strobe.

Top module: `stack_ext_unit`

## Requirements
- R1: After a synchronous active-low reset the stack pointer reads 0x07, the extension register reads 0xFC, both memory strobes are low, and busy and done are low.
- R2: A push first increments the stack pointer and then writes. In the request cycle, mem_we is high, mem_re is low, mem_wdata carries the byte and mem_addr is the incremented location. The stack pointer shows the new value from the next cycle.
- R3: A pop reads at the current stack pointer with mem_re high in the request cycle, then decrements it. The byte read appears on pop_data with pop_valid high in the next cycle.
- R4: With the wide mode enabled, mem_addr equals the extension bits [1:0] times 256 plus the stack pointer, and mem_ext_sel is 1. With it disabled, mem_addr bits [11:8] are 0 and mem_ext_sel is 0.
- R5: In wide mode, a push that wraps the stack pointer from 0xFF to 0x00 increments extension bits [1:0]. In narrow mode the same push leaves the extension register unchanged.
- R6: In wide mode, a pop that takes the stack pointer from 0x00 to 0xFF decrements extension bits [1:0].
- R7: Carry and borrow touch only extension bits [1:0], which wrap modulo 4. Bits [7:2] keep their written value.
- R8: sp_wr loads reg_wdata into the stack pointer and ext_wr loads it into the extension register. Both take effect only in a cycle without a stack transfer.
- R9: A call starts the cycle after call_req. It pushes call_pc byte 0, then byte 1, then byte 2 when flat_mode is set, one byte per clock. done pulses for one cycle in the clock after the last push, and pc_out then holds call_target. The top byte of pc_out is 0 when flat_mode is clear.
- R10: An interrupt call (call_irq=1) in flat mode still pushes three bytes, but pc_out[23:16] is 0.
- R11: A return pops byte 2 first (flat mode only), then byte 1, then byte 0, one per clock. done and pc_out, holding the rebuilt address, appear in the clock after the last pop without flat mode, and one clock later with flat mode.
- R12: While a frame runs, busy is high and push, pop, call and return requests are ignored. When idle, one request is served per cycle in the priority order call, return, push, pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_en | input | 1 | Wide (10-bit) stack mode |
| flat_mode | input | 1 | 24-bit address mode: three-byte frames |
| push_req | input | 1 | Single-byte push request |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Single-byte pop request |
| call_req | input | 1 | Start a call frame |
| call_irq | input | 1 | Call is an interrupt entry |
| call_pc | input | 24 | Return address to save |
| call_target | input | 24 | Destination address of the call |
| ret_req | input | 1 | Start a return frame |
| sp_wr | input | 1 | Load stack pointer from reg_wdata |
| ext_wr | input | 1 | Load extension register from reg_wdata |
| reg_wdata | input | 8 | Data for direct register loads |
| mem_rdata | input | 8 | Read data from the selected RAM |
| mem_addr | output | 12 | Stack RAM address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_ext_sel | output | 1 | 1 selects the 4 KB RAM, 0 the 256-byte RAM |
| pop_data | output | 8 | Byte of the last single pop |
| pop_valid | output | 1 | pop_data valid pulse |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Frame finished pulse |
| pc_out | output | 24 | Target of a call or address restored by a return |
| sp_q | output | 8 | Stack pointer |
| ext_q | output | 8 | Extension register |

## Verification
Random runs of single pushes and pops, with the wide mode toggled between them, are compared with a reference stack. This separates a correct pre-increment and post-decrement from an off-by-one location, and a correct wide address from one that ignores the extension bits. Directed sequences park the pointer at 0xFF and 0x00 with the extension field at 3 and 0, and with non-zero upper bits. These separate a two-bit carry or borrow from an eight-bit one, and a carry that happens in narrow mode from one that correctly does not. Call and return frames are run in narrow, flat and interrupt form, and each byte's address and value is checked in its own cycle. This catches a swapped byte order, a missing third byte, a non-zero interrupt vector top byte, and a missing extra return cycle. A push request raised during a frame, and a push and a pop raised together, confirm that busy blocks requests and that push wins over pop.

// File: rtl/stk_pkg.sv
// Shared definitions for the extended stack pointer unit.
// Assumes byte-wide stack storage.
package stk_pkg;
    localparam int unsigned BYTE_W = 8;

    // Frame sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CALL = 2'd1,
        SQ_RET  = 2'd2,
        SQ_TAIL = 2'd3
    } seq_state_t;
endpackage

// File: rtl/stk_ptr.sv
// Stack pointer plus extension register, with address generation.
// Does: pre-increment on push, post-decrement on pop, and carry/borrow
// into the low XB extension bits when ext_en is set.
// Assumes: do_push and do_pop are never high together. Direct loads are
// only honoured in cycles without a transfer.
module stk_ptr #(
    parameter int SP_W   = 8,
    parameter int XB     = 2,
    parameter int ADDR_W = 12,
    parameter logic [SP_W-1:0] SP_RST  = 8'h07,
    parameter logic [SP_W-1:0] EXT_RST = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_en,
    input  logic              do_push,
    input  logic              do_pop,
    input  logic              wr_sp,
    input  logic              wr_ext,
    input  logic [SP_W-1:0]   wr_data,
    output logic [SP_W-1:0]   sp,
    output logic [SP_W-1:0]   ext,
    output logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] pop_addr
);
    localparam int PAD_W = ADDR_W - XB - SP_W;
    localparam int NAR_W = ADDR_W - SP_W;

    logic [SP_W-1:0] sp_up, sp_dn;
    logic [XB-1:0]   xi_up, xi_dn;
    logic            wrap_up, wrap_dn;

    // Next pointer values and the addresses they form
    always_comb begin
        sp_up   = sp + 1'b1;
        sp_dn   = sp - 1'b1;
        wrap_up = ext_en && (sp == '1);
        wrap_dn = ext_en && (sp == '0);
        xi_up   = ext[XB-1:0] + XB'(wrap_up);
        xi_dn   = ext[XB-1:0] - XB'(wrap_dn);
        if (ext_en) begin
            push_addr = {{PAD_W{1'b0}}, xi_up, sp_up};
            pop_addr  = {{PAD_W{1'b0}}, ext[XB-1:0], sp};
        end else begin
            push_addr = {{NAR_W{1'b0}}, sp_up};
            pop_addr  = {{NAR_W{1'b0}}, sp};
        end
    end

    // Register update: transfers first, then direct loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp  <= SP_RST;
            ext <= EXT_RST;
        end else if (do_push) begin
            sp          <= sp_up;
            ext[XB-1:0] <= xi_up;
        end else if (do_pop) begin
            sp          <= sp_dn;
            ext[XB-1:0] <= xi_dn;
        end else begin
            if (wr_sp)  sp  <= wr_data;
            if (wr_ext) ext <= wr_data;
        end
    end
endmodule

// File: rtl/stk_seq.sv
// Request arbiter and call/return frame sequencer.
// Does: serves one single-byte request per idle cycle (call > ret > push >
// pop), and runs call and return frames one byte per clock.
// Assumes: mem_rdata is valid in the same cycle as do_pop.
module stk_seq
    import stk_pkg::*;
#(
    parameter int PC_W   = 24,
    parameter int BASE_B = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flat,
    input  logic            push_req,
    input  logic [BYTE_W-1:0] push_data,
    input  logic            pop_req,
    input  logic            call_req,
    input  logic            call_irq,
    input  logic [PC_W-1:0] call_pc,
    input  logic [PC_W-1:0] call_target,
    input  logic            ret_req,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic            do_push,
    output logic            do_pop,
    output logic [BYTE_W-1:0] wdata,
    output logic            busy,
    output logic            done,
    output logic [PC_W-1:0] pc_out,
    output logic            pop_valid,
    output logic [BYTE_W-1:0] pop_data
);
    localparam int NB = PC_W / BYTE_W;
    localparam int IW = $clog2(NB + 1);

    seq_state_t                     state;
    logic [IW-1:0]                  idx, nb, ret_pos;
    logic                           flat_q, irq_q, idle, last;
    logic [PC_W-1:0]                pc_q, tgt_q;
    logic [NB-1:0][BYTE_W-1:0]      rbytes;

    // Strobe arbitration and current frame position
    always_comb begin
        idle    = (state == SQ_IDLE);
        last    = (idx == nb - 1'b1);
        ret_pos = nb - 1'b1 - idx;
        busy    = !idle;
        do_push = idle ? (push_req && !call_req && !ret_req) : (state == SQ_CALL);
        do_pop  = idle ? (pop_req && !push_req && !call_req && !ret_req)
                       : (state == SQ_RET);
        wdata   = idle ? push_data : pc_q[BYTE_W*int'(idx) +: BYTE_W];
    end

    // Frame state machine, result assembly and single-pop capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            idx       <= '0;
            nb        <= '0;
            flat_q    <= 1'b0;
            irq_q     <= 1'b0;
            pc_q      <= '0;
            tgt_q     <= '0;
            rbytes    <= '0;
            done      <= 1'b0;
            pc_out    <= '0;
            pop_valid <= 1'b0;
            pop_data  <= '0;
        end else begin
            done      <= 1'b0;
            pop_valid <= idle && do_pop;
            if (idle && do_pop) pop_data <= mem_rdata;
            case (state)
                SQ_IDLE: begin
                    idx    <= '0;
                    flat_q <= flat;
                    nb     <= flat ? IW'(NB) : IW'(BASE_B);
                    if (call_req) begin
                        pc_q  <= call_pc;
                        tgt_q <= call_target;
                        irq_q <= call_irq;
                        state <= SQ_CALL;
                    end else if (ret_req) begin
                        state <= SQ_RET;
                    end
                end
                SQ_CALL: begin
                    if (last) begin
                        state <= SQ_IDLE;
                        done  <= 1'b1;
                        for (int k = 0; k < NB; k++)
                            pc_out[BYTE_W*k +: BYTE_W] <=
                                (k < int'(nb) && !(irq_q && k >= BASE_B))
                                ? tgt_q[BYTE_W*k +: BYTE_W] : '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SQ_RET: begin
                    rbytes[ret_pos] <= mem_rdata;
                    if (last) begin
                        if (flat_q) begin
                            state <= SQ_TAIL;
                        end else begin
                            state <= SQ_IDLE;
                            done  <= 1'b1;
                            for (int k = 0; k < NB; k++)
                                pc_out[BYTE_W*k +: BYTE_W] <=
                                    (k == 0) ? mem_rdata :
                                    (k < int'(nb)) ? rbytes[k] : '0;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SQ_TAIL: begin
                    state  <= SQ_IDLE;
                    done   <= 1'b1;
                    pc_out <= rbytes;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stack_ext_unit.sv
// Extended stack pointer unit: top level.
// Does: joins the pointer and the frame sequencer and drives the RAM strobes.
// Assumes: ext_en and flat_mode are static while a frame runs, and the RAM
// reads asynchronously.
module stack_ext_unit #(
    parameter int SP_W   = 8,
    parameter int XB     = 2,
    parameter int ADDR_W = 12,
    parameter int PC_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_en,
    input  logic              flat_mode,
    input  logic              push_req,
    input  logic [7:0]        push_data,
    input  logic              pop_req,
    input  logic              call_req,
    input  logic              call_irq,
    input  logic [PC_W-1:0]   call_pc,
    input  logic [PC_W-1:0]   call_target,
    input  logic              ret_req,
    input  logic              sp_wr,
    input  logic              ext_wr,
    input  logic [SP_W-1:0]   reg_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [7:0]        mem_wdata,
    output logic              mem_ext_sel,
    output logic [7:0]        pop_data,
    output logic              pop_valid,
    output logic              busy,
    output logic              done,
    output logic [PC_W-1:0]   pc_out,
    output logic [SP_W-1:0]   sp_q,
    output logic [SP_W-1:0]   ext_q
);
    logic              do_push, do_pop;
    logic [ADDR_W-1:0] push_addr, pop_addr;

    stk_seq #(.PC_W(PC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .flat(flat_mode),
        .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
        .call_req(call_req), .call_irq(call_irq), .call_pc(call_pc),
        .call_target(call_target), .ret_req(ret_req), .mem_rdata(mem_rdata),
        .do_push(do_push), .do_pop(do_pop), .wdata(mem_wdata),
        .busy(busy), .done(done), .pc_out(pc_out),
        .pop_valid(pop_valid), .pop_data(pop_data)
    );

    stk_ptr #(.SP_W(SP_W), .XB(XB), .ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en),
        .do_push(do_push), .do_pop(do_pop),
        .wr_sp(sp_wr), .wr_ext(ext_wr), .wr_data(reg_wdata),
        .sp(sp_q), .ext(ext_q), .push_addr(push_addr), .pop_addr(pop_addr)
    );

    // RAM strobes and address select
    always_comb begin
        mem_we      = do_push;
        mem_re      = do_pop;
        mem_addr    = do_push ? push_addr : pop_addr;
        mem_ext_sel = ext_en;
    end
endmodule

// File: rtl/stk_chk.sv
// Property checker for stack_ext_unit, attached by bind.
// Assumes the default widths (8-bit pointer, 2 extension bits, 12-bit address).
module stk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ext_en,
    input logic        mem_we,
    input logic        mem_re,
    input logic [11:0] mem_addr,
    input logic [7:0]  sp_q,
    input logic [7:0]  ext_q,
    input logic        busy,
    input logic        done
);
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_q == $past(sp_q) + 8'd1);
    p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_q == $past(sp_q) - 8'd1);
    p_narrow_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && !ext_en) |-> mem_addr[11:8] == 4'd0);
    p_wide_pop_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && ext_en) |-> mem_addr == {2'b00, ext_q[1:0], sp_q});
    p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ext_en && sp_q == 8'hFF) |=> ext_q[1:0] == $past(ext_q[1:0]) + 2'd1);
    p_borrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && ext_en && sp_q == 8'h00) |=> ext_q[1:0] == $past(ext_q[1:0]) - 2'd1);
    p_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |=> ext_q[7:2] == $past(ext_q[7:2]));
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind stack_ext_unit stk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .sp_q(sp_q), .ext_q(ext_q),
    .busy(busy), .done(done)
);

// File: tb/sim_stack_ext_unit.sv
`timescale 1ns/1ps
module sim_stack_ext_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_en = 0, flat_mode = 0, push_req = 0, pop_req = 0;
    logic call_req = 0, call_irq = 0, ret_req = 0, sp_wr = 0, ext_wr = 0;
    logic [7:0]  push_data = 0, reg_wdata = 0, mem_rdata;
    logic [23:0] call_pc = 0, call_target = 0, pc_out;
    logic [11:0] mem_addr;
    logic mem_we, mem_re, mem_ext_sel, pop_valid, busy, done;
    logic [7:0] mem_wdata, pop_data, sp_q, ext_q;

    int n_chk = 0, n_fail = 0;
    int m_sp, m_ext;
    logic [7:0] pm_x [0:4095];
    logic [7:0] pm_i [0:255];
    logic [7:0] ref_m [0:8191];

    always #2.5 clk = ~clk;

    stack_ext_unit u0 (.*);

    assign mem_rdata = mem_ext_sel ? pm_x[mem_addr] : pm_i[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) begin
        if (mem_ext_sel) pm_x[mem_addr] <= mem_wdata;
        else pm_i[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int f_addr(int s, int x, bit en);
        return en ? ((x & 3) * 256 + s) : s;
    endfunction
    function automatic int f_ext_up(int s, int x, bit en);
        return (en && s == 255) ? ((x & 'hFC) | ((x + 1) & 3)) : x;
    endfunction
    function automatic int f_ext_dn(int s, int x, bit en);
        return (en && s == 0) ? ((x & 'hFC) | ((x - 1) & 3)) : x;
    endfunction

    // One push transfer, checked in its cycle (at negedge + 1)
    task automatic chk_push_now(int d, string req);
        int a;
        m_ext = f_ext_up(m_sp, m_ext, ext_en);
        m_sp  = (m_sp + 1) & 255;
        a = f_addr(m_sp, m_ext, ext_en);
        check({req, " we"}, mem_we, 1);
        check({req, " re"}, mem_re, 0);
        check({req, " addr"}, mem_addr, a);
        check({req, " wdata"}, mem_wdata, d);
        check("R4 sel", mem_ext_sel, ext_en);
        ref_m[ext_en * 4096 + a] = d[7:0];
    endtask

    function automatic int pop_model(bit en);
        int a, d;
        a = f_addr(m_sp, m_ext, en);
        d = ref_m[en * 4096 + a];
        m_ext = f_ext_dn(m_sp, m_ext, en);
        m_sp = (m_sp - 1) & 255;
        return a * 256 + d;
    endfunction

    task automatic do_push(int d);
        @(negedge clk); push_req = 1; push_data = d[7:0]; #1;
        chk_push_now(d, "R2 push");
        @(negedge clk); push_req = 0; #1;
        check("R2 sp after push", sp_q, m_sp);
        check("R5 ext after push", ext_q, m_ext);
    endtask

    task automatic do_pop();
        int r;
        @(negedge clk); pop_req = 1; #1;
        r = pop_model(ext_en);
        check("R3 re", mem_re, 1);
        check("R3 we", mem_we, 0);
        check("R4 pop addr", mem_addr, r / 256);
        @(negedge clk); pop_req = 0; #1;
        check("R3 pop_valid", pop_valid, 1);
        check("R3 pop_data", pop_data, r % 256);
        check("R3 sp after pop", sp_q, m_sp);
        check("R6 ext after pop", ext_q, m_ext);
    endtask

    task automatic wr_regs(int s, int x);
        @(negedge clk); sp_wr = 1; reg_wdata = s[7:0];
        @(negedge clk); sp_wr = 0; ext_wr = 1; reg_wdata = x[7:0];
        @(negedge clk); ext_wr = 0; #1;
        m_sp = s; m_ext = x;
        check("R8 sp load", sp_q, s);
        check("R8 ext load", ext_q, x);
    endtask

    task automatic do_call(int pc, int tgt, bit irq, bit fl);
        int nb, exp;
        nb = fl ? 3 : 2;
        flat_mode = fl;
        @(negedge clk); call_req = 1; call_irq = irq; call_pc = pc[23:0]; call_target = tgt[23:0];
        @(negedge clk); call_req = 0;
        for (int k = 0; k < nb; k++) begin
            if (k == 0) begin push_req = 1; push_data = 8'hEE; end
            #1;
            check("R12 busy", busy, 1);
            chk_push_now((pc >> (8 * k)) & 255, "R9 call byte");
            check("R9 no early done", done, 0);
            @(negedge clk); push_req = 0;
        end
        #1;
        exp = fl ? (irq ? (tgt & 'hFFFF) : (tgt & 'hFFFFFF)) : (tgt & 'hFFFF);
        check("R9 done", done, 1);
        check(irq ? "R10 irq vector" : "R9 target", pc_out, exp);
        check("R12 sp unaffected by held push", sp_q, m_sp);
    endtask

    task automatic do_ret(int exp, bit fl);
        int nb, r;
        nb = fl ? 3 : 2;
        flat_mode = fl;
        @(negedge clk); ret_req = 1;
        @(negedge clk); ret_req = 0;
        for (int k = 0; k < nb; k++) begin
            #1;
            r = pop_model(ext_en);
            check("R11 ret re", mem_re, 1);
            check("R11 ret addr", mem_addr, r / 256);
            check("R11 ret byte order", mem_rdata, (exp >> (8 * (nb - 1 - k))) & 255);
            @(negedge clk);
        end
        #1;
        if (fl) begin
            check("R11 flat extra cycle", done, 0);
            check("R11 extra cycle idle", mem_re, 0);
            @(negedge clk); #1;
        end
        check("R11 done", done, 1);
        check("R11 restored pc", pc_out, exp);
        check("R11 sp after ret", sp_q, m_sp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5A17);
        for (int i = 0; i < 4096; i++) pm_x[i] = 0;
        for (int i = 0; i < 256; i++) pm_i[i] = 0;
        for (int i = 0; i < 8192; i++) ref_m[i] = 0;
        m_sp = 'h07; m_ext = 'hFC;
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        check("R1 sp reset", sp_q, 'h07);
        check("R1 ext reset", ext_q, 'hFC);
        check("R1 strobes", {mem_we, mem_re}, 0);
        check("R1 busy/done", {busy, done}, 0);

        // basic push/pop, narrow mode
        do_push('h3C); do_push('hA5); do_pop(); do_pop();

        // wide address with nonzero index
        ext_en = 1;
        wr_regs('h10, 'h02);
        do_push('h11); do_pop();

        // carry and borrow with upper bits kept (R5, R6, R7)
        wr_regs('hFF, 'h27);
        do_push('h77);
        check("R7 upper kept on carry", ext_q, 'h24);
        do_pop();
        check("R7 upper kept on borrow", ext_q, 'h27);
        wr_regs('h00, 'hB0);
        do_pop();
        check("R7 borrow wraps to 3", ext_q, 'hB3);

        // narrow mode: no carry
        ext_en = 0;
        wr_regs('hFF, 'h5E);
        do_push('h42);
        check("R5 no carry in narrow", ext_q, 'h5E);

        // push and pop together: push wins (R12)
        @(negedge clk); push_req = 1; pop_req = 1; push_data = 8'h9D; #1;
        chk_push_now('h9D, "R12 priority");
        @(negedge clk); push_req = 0; pop_req = 0; #1;
        check("R12 sp after priority", sp_q, m_sp);

        // frames
        wr_regs('h40, 'hFC);
        do_call('h12_3456, 'hAB_CDEF, 0, 0);
        do_ret('h00_3456, 0);
        ext_en = 1;
        wr_regs('hFE, 'hFD);
        do_call('h9A_BC01, 'h31_2468, 0, 1);
        do_ret('h9A_BC01, 1);
        do_call('h07_0203, 'h55_0033, 1, 1);
        do_ret('h07_0203, 1);
        flat_mode = 0;

        // random single-byte traffic
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 19);
            if (op == 0) ext_en = ~ext_en;
            else if (op < 10) do_push($urandom_range(0, 255));
            else do_pop();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule